// File: doc/BRIEF.md
# Packed Integer Add/Subtract Datapath

This block adds or subtracts two 128-bit vectors of packed integers. The vectors are split into lanes of 8, 16, 32 or 64 bits, chosen for each request. Each lane is computed on its own. The result of a lane can wrap around, clamp to the signed range, or clamp to the unsigned range. Clamping exists only for 8-bit and 16-bit lanes. A request that asks for clamping at 32 or 64 bits, or that uses the reserved mode code, raises a mode error, and the block returns the wrapped result instead.

One adder built from 8-bit segments serves every lane width. A segment's carry either continues from the segment below it or restarts at the lane's own carry-in. The lane-size select decides which. Every accepted request is registered, and the result appears on the next cycle.

The output stage is a two-state machine:
- `OUT_EMPTY` holds no fresh result.
- `OUT_FULL` presents a result for one cycle.
- Any cycle with `in_valid` high moves the machine to `OUT_FULL`, from either state.
- Any cycle with `in_valid` low moves it to `OUT_EMPTY`.
- Reset enters `OUT_EMPTY`.

Top module: `simd_addsub`

## Requirements
- R1: With `mode_sel`=0 (wrap) and `op_sub`=0, each lane of `result` holds the low lane-width bits of the sum of the matching `op_a` and `op_b` lanes. The `lane_sel` codes are 0→8, 1→16, 2→32 and 3→64 bits, with lane 0 in the least significant bits. No carry passes from one lane into the next.
- R2: With `mode_sel`=0 and `op_sub`=1, each lane holds `op_a` lane minus `op_b` lane, modulo 2^width. The borrow is discarded.
- R3: With `mode_sel`=1 (signed clamping) and `lane_sel` 0 or 1, a lane whose exact signed result exceeds the lane's maximum gives that maximum (0x7F or 0x7FFF). A result below the minimum gives the minimum (0x80 or 0x8000). This applies to both add and subtract.
- R4: With `mode_sel`=2 (unsigned clamping) and `lane_sel` 0 or 1, an add that overflows gives all ones in that lane. A subtract that goes below zero gives zero.
- R5: `mode_err` is set with the result when either of these holds: `mode_sel`=3, or `mode_sel` is 1 or 2 with `lane_sel` 2 or 3. The result is then the wrap-mode result of the same operation. Otherwise `mode_err` is 0.
- R6: `result_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1, and 0 otherwise. `result` and `mode_err` keep their values across cycles with `in_valid`=0.
- R7: After reset, `result_valid`, `result` and `mode_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_a | input | 128 | First operand (minuend) |
| op_b | input | 128 | Second operand (subtrahend) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| lane_sel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| mode_sel | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 reserved |
| result_valid | output | 1 | Registered result present |
| result | output | 128 | Registered packed result |
| mode_err | output | 1 | Illegal mode/width pairing in the request |

## Verification
- **Broken carry join.** A wrong join between segments shows up as a carry leaking into the next lane, or as a lane split in the middle. The next registered result carries a wrong byte at the lane boundary.
- **Wrong clamp.** A wrong clamp decision shows as a value other than the limit at the saturating boundaries (0, maximum, minimum).
- **Wrong output state.** A wrong state in the output machine shows as `result_valid` out of step with `in_valid` on the following cycle.
- **How soon.** Every fault appears at the ports one clock after the request that triggers it.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        ARITH_WRAP = 2'd0,
        ARITH_SSAT = 2'd1,
        ARITH_USAT = 2'd2,
        ARITH_RSVD = 2'd3
    } arith_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/simd_lane_ctl.sv
module simd_lane_ctl
    import simd_addsub_pkg::*;
#(
    parameter int NSEG = 16
) (
    input  logic [1:0]      lane_sel,
    input  logic [1:0]      mode_sel,
    output logic [NSEG-1:0] seg_join,
    output logic            sat_en,
    output logic            sat_uns,
    output logic            illegal
);
    lane_e  lane;
    arith_e arith;

    assign lane  = lane_e'(lane_sel);
    assign arith = arith_e'(mode_sel);

    // A segment joins the one below it unless it starts a lane.
    for (genvar g = 0; g < NSEG; g++) begin : g_join
        always_comb begin
            unique case (lane)
                LANE_B8:  seg_join[g] = 1'b0;
                LANE_B16: seg_join[g] = (g % 2) != 0;
                LANE_B32: seg_join[g] = (g % 4) != 0;
                default:  seg_join[g] = (g % 8) != 0;
            endcase
        end
    end

    always_comb begin
        illegal = 1'b0;
        unique case (arith)
            ARITH_WRAP:             illegal = 1'b0;
            ARITH_SSAT, ARITH_USAT: illegal = (lane == LANE_B32) || (lane == LANE_B64);
            default:                illegal = 1'b1;
        endcase
        sat_en  = !illegal && (arith != ARITH_WRAP);
        sat_uns = (arith == ARITH_USAT);
    end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter int DATA_W = 128,
    parameter int SEG_W  = 8,
    localparam int NSEG  = DATA_W / SEG_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              lane_cin,
    input  logic [NSEG-1:0]   seg_join,
    output logic [DATA_W-1:0] sum,
    output logic [NSEG-1:0]   seg_cout
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic             ci;
        logic             co;
        logic [SEG_W-1:0] s;
        if (g == 0) begin : g_first
            assign ci = lane_cin;
        end else begin : g_rest
            assign ci = seg_join[g] ? g_seg[g-1].co : lane_cin;
        end
        assign {co, s} = {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b[g*SEG_W +: SEG_W]}
                         + {{SEG_W{1'b0}}, ci};
        assign sum[g*SEG_W +: SEG_W] = s;
        assign seg_cout[g] = co;
    end

endmodule

// File: rtl/simd_sat_unit.sv
module simd_sat_unit
    import simd_addsub_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int SEG_W  = 8,
    localparam int NSEG  = DATA_W / SEG_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b_eff,
    input  logic [DATA_W-1:0] sum,
    input  logic [NSEG-1:0]   seg_cout,
    input  logic              is_sub,
    input  logic [1:0]        lane_sel,
    input  logic              sat_en,
    input  logic              sat_uns,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] clamp_res [2];

    // Clamped results for one-segment and two-segment lanes.
    for (genvar k = 0; k < 2; k++) begin : g_width
        localparam int LW    = SEG_W << k;
        localparam int NLANE = DATA_W / LW;
        for (genvar j = 0; j < NLANE; j++) begin : g_lane
            localparam int TOP = j * (1 << k) + (1 << k) - 1;
            logic          sa, sb, sr, ovf_s, ovf_u;
            logic [LW-1:0] lane_out;
            assign sa    = a[(j+1)*LW-1];
            assign sb    = b_eff[(j+1)*LW-1];
            assign sr    = sum[(j+1)*LW-1];
            assign ovf_s = (sa == sb) && (sr != sa);
            // Add overflows on carry out; subtract underflows on missing carry.
            assign ovf_u = is_sub ? !seg_cout[TOP] : seg_cout[TOP];
            always_comb begin
                lane_out = sum[j*LW +: LW];
                if (sat_uns) begin
                    if (ovf_u) lane_out = is_sub ? {LW{1'b0}} : {LW{1'b1}};
                end else if (ovf_s) begin
                    lane_out = sa ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
                end
            end
            assign clamp_res[k][j*LW +: LW] = lane_out;
        end
    end

    always_comb begin
        res = sum;
        if (sat_en) begin
            unique case (lane_e'(lane_sel))
                LANE_B8:  res = clamp_res[0];
                LANE_B16: res = clamp_res[1];
                default:  res = sum;
            endcase
        end
    end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        mode_sel,
    output logic              result_valid,
    output logic [DATA_W-1:0] result,
    output logic              mode_err
);
    localparam int NSEG = DATA_W / SEG_W;

    logic [NSEG-1:0]   seg_join;
    logic [NSEG-1:0]   seg_cout;
    logic              sat_en, sat_uns, illegal;
    logic [DATA_W-1:0] b_eff, sum, comb_res;
    out_state_e        state_q, state_d;

    assign b_eff = op_sub ? ~op_b : op_b;

    simd_lane_ctl #(.NSEG(NSEG)) ctl_i (
        .lane_sel (lane_sel),
        .mode_sel (mode_sel),
        .seg_join (seg_join),
        .sat_en   (sat_en),
        .sat_uns  (sat_uns),
        .illegal  (illegal)
    );

    simd_seg_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) add_i (
        .a        (op_a),
        .b        (b_eff),
        .lane_cin (op_sub),
        .seg_join (seg_join),
        .sum      (sum),
        .seg_cout (seg_cout)
    );

    simd_sat_unit #(.DATA_W(DATA_W), .SEG_W(SEG_W)) sat_i (
        .a        (op_a),
        .b_eff    (b_eff),
        .sum      (sum),
        .seg_cout (seg_cout),
        .is_sub   (op_sub),
        .lane_sel (lane_sel),
        .sat_en   (sat_en),
        .sat_uns  (sat_uns),
        .res      (comb_res)
    );

    // Output state machine: next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: state_d = in_valid ? OUT_FULL : OUT_EMPTY;
            OUT_FULL:  state_d = in_valid ? OUT_FULL : OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            mode_err <= 1'b0;
        end else if (in_valid) begin
            result   <= comb_res;
            mode_err <= illegal;
        end
    end

    assign result_valid = (state_q == OUT_FULL);

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result_valid);
    assert_valid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !result_valid);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(mode_err)));
    assert_err_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_sel == 2'd3 || (mode_sel != 2'd0 && lane_sel[1]))) |=> mode_err);
    assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd0) |=> !mode_err);
    assert_no_cross_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd0 && lane_sel == 2'd0 && !op_sub
         && op_a[15:0] == 16'h00FF && op_b[15:0] == 16'h0001) |=> result[15:0] == 16'h0000);
    assert_ssat_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd1 && lane_sel == 2'd0 && !op_sub
         && op_a[7:0] == 8'h7F && op_b[7:0] == 8'h7F) |=> result[7:0] == 8'h7F);
    assert_usat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd2 && lane_sel == 2'd0 && !op_sub
         && op_a[7:0] == 8'hFF && op_b[7:0] != 8'h00) |=> result[7:0] == 8'hFF);

endmodule

// File: tb/simd_addsub_tb_top.sv
`timescale 1ns/1ps
module simd_addsub_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0, op_b = '0;
    logic         op_sub = 1'b0;
    logic [1:0]   lane_sel = '0, mode_sel = '0;
    logic         result_valid;
    logic [127:0] result;
    logic         mode_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic         exp_valid = 1'b0;
    logic [127:0] exp_res = '0;
    logic         exp_err = 1'b0;
    string        exp_tag = "R7";

    always #2.5 clk = ~clk;

    simd_addsub dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .lane_sel(lane_sel), .mode_sel(mode_sel),
        .result_valid(result_valid), .result(result), .mode_err(mode_err)
    );

    function automatic void ref_calc(input logic [127:0] a, input logic [127:0] b,
                                     input logic sub, input logic [1:0] ls, input logic [1:0] md,
                                     output logic [127:0] r, output logic e, output string tag);
        int w = 8 << ls;
        int n = 128 / w;
        logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        e = (md == 2'd3) || (md != 2'd0 && ls >= 2'd2);
        r = '0;
        if (e)               tag = "R5";
        else if (md == 2'd1) tag = "R3";
        else if (md == 2'd2) tag = "R4";
        else if (sub)        tag = "R2";
        else                 tag = "R1";
        for (int i = 0; i < n; i++) begin
            logic [63:0] x = 64'(a >> (i * w)) & m;
            logic [63:0] y = 64'(b >> (i * w)) & m;
            logic [63:0] z = (sub ? x - y : x + y) & m;
            longint sx, sy, sr, lim;
            if (!e && md == 2'd1) begin
                sx = x[w-1] ? longint'(x) - (longint'(1) << w) : longint'(x);
                sy = y[w-1] ? longint'(y) - (longint'(1) << w) : longint'(y);
                sr = sub ? sx - sy : sx + sy;
                lim = longint'(1) << (w - 1);
                if (sr > lim - 1) sr = lim - 1;
                if (sr < -lim)    sr = -lim;
                z = 64'(sr) & m;
            end else if (!e && md == 2'd2) begin
                sr = sub ? longint'(x) - longint'(y) : longint'(x) + longint'(y);
                if (sr < 0)            sr = 0;
                if (sr > longint'(m))  sr = longint'(m);
                z = 64'(sr);
            end
            r = r | (128'(z) << (i * w));
        end
    endfunction

    // Reference model: capture expectations at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_res   <= '0;
            exp_err   <= 1'b0;
            exp_tag   <= "R7";
        end else if (in_valid) begin
            logic [127:0] r;
            logic e;
            string t;
            ref_calc(op_a, op_b, op_sub, lane_sel, mode_sel, r, e, t);
            exp_valid <= 1'b1;
            exp_res   <= r;
            exp_err   <= e;
            exp_tag   <= t;
        end else begin
            exp_valid <= 1'b0;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (result_valid !== exp_valid) begin
                errors++;
                $display("FAIL R6 result_valid actual %0b expected %0b", result_valid, exp_valid);
            end
            checks++;
            if (result !== exp_res) begin
                errors++;
                $display("FAIL %s result actual %h expected %h", exp_tag, result, exp_res);
            end
            checks++;
            if (mode_err !== exp_err) begin
                errors++;
                $display("FAIL R5 mode_err actual %0b expected %0b", mode_err, exp_err);
            end
        end
    end

    task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic sub,
                         input logic [1:0] ls, input logic [1:0] md);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; op_sub = sub; lane_sel = ls; mode_sel = md;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = {4{$urandom}}; op_b = {4{$urandom}};
        end
    endtask

    function automatic logic [127:0] fill(input logic [63:0] v, input int w);
        logic [127:0] r = '0;
        for (int i = 0; i < 128 / w; i++) r = r | (128'(v) << (i * w));
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        // R7: reset state
        checks++;
        if (result_valid !== 1'b0 || result !== '0 || mode_err !== 1'b0) begin
            errors++;
            $display("FAIL R7 reset outputs actual %0b/%h/%0b expected 0/0/0",
                     result_valid, result, mode_err);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R1: carry must not cross byte lanes
        drive({8{16'h00FF}}, {8{16'h0001}}, 1'b0, 2'd0, 2'd0);
        // Boundary values for each width, mode and direction (R1..R5)
        for (int ls = 0; ls < 4; ls++) begin
            int w = 8 << ls;
            logic [63:0] mx = (w == 64) ? '1 : ((64'd1 << w) - 1);
            logic [63:0] smax = mx >> 1;
            logic [63:0] smin = smax + 64'd1;
            logic [63:0] vals [5];
            vals[0] = 64'd0; vals[1] = mx; vals[2] = smax; vals[3] = smin; vals[4] = 64'd1;
            for (int md = 0; md < 4; md++)
                for (int s = 0; s < 2; s++)
                    for (int i = 0; i < 5; i++)
                        for (int j = 0; j < 5; j++)
                            drive(fill(vals[i], w), fill(vals[j], w), s[0], 2'(ls), 2'(md));
        end
        idle(3);
        // Random vectors with idle gaps (R6 holding)
        for (int k = 0; k < 800; k++) begin
            drive({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                  1'($urandom), 2'($urandom), 2'($urandom));
            if (k % 7 == 0) idle(1 + k % 3);
        end
        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule